// File: doc/BRIEF.md
# Serial SAR ADC Readout Controller

This block is the host side of a three-wire link to a successive-approximation converter. A single-cycle start request pulls the active-low select line down, which both launches the conversion and opens the data transfer in the same frame. The controller then generates the data clock from the system clock with a programmable divider. It lets the sampling lead-in and the forced-low null bit pass, and captures the RES_BITS result bits, most significant first, on the rising edges of the data clock.

The result appears left-aligned in a WORD_W-bit parallel word, with the unused low bits forced to zero. A one-cycle strobe marks it, and an error flag reports a null bit that read high. The controller then raises select, which puts the converter in shutdown, and holds it high for a full data-clock period before it accepts another request. The half-period of the data clock is taken from an input when the request is accepted and is clamped to a legal window, so the converter's minimum high/low time and frequency limits hold whatever value software writes.

Top module: `sar_rd_ctrl`

## Requirements
- R1: While reset is applied and after it is released, with no request, cs_n is 1, sclk is 0, busy is 0 and word_vld is 0.
- R2: A start pulse while idle lowers cs_n and raises busy at the next clock edge. busy then stays high for exactly (2*RES_BITS+8)*H system cycles, where H is the effective half-period.
- R3: H is half_period clamped to [MIN_HALF, MAX_HALF], latched when the request is accepted. Every high phase of sclk lasts exactly H system cycles, even if half_period changes during the frame.
- R4: Each frame gives exactly RES_BITS+3 rising edges of sclk while cs_n is low. cs_n stays low for (2*RES_BITS+6)*H cycles, and sclk is 0 whenever cs_n changes.
- R5: sdi is sampled on rising edges of sclk. The third rising edge reads the null bit, and rising edges 4 through RES_BITS+3 read the result, most significant bit first.
- R6: word carries the result in bits [WORD_W-1 : WORD_W-RES_BITS] with all lower bits 0. word_vld is high for exactly one cycle per frame, while cs_n is still low.
- R7: frame_err equals the sampled null bit during the word_vld cycle and is 0 whenever word_vld is 0.
- R8: After cs_n rises it stays high, and busy stays high, for exactly 2*H further cycles before a new request can be taken.
- R9: A start pulse while busy is high has no effect: it produces no additional cs_n falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle conversion request |
| half_period | input | DIV_W | Requested data-clock half-period in system cycles |
| cs_n | output | 1 | Active-low converter select; high means shutdown |
| sclk | output | 1 | Generated data clock |
| sdi | input | 1 | Serial data from the converter |
| busy | output | 1 | Frame or post-frame guard in progress |
| word | output | WORD_W | Left-aligned result |
| word_vld | output | 1 | One-cycle strobe for word |
| frame_err | output | 1 | Null bit read high, valid with word_vld |

## Verification
A wrong edge count or misplaced sample index shows up at once in the captured word of that frame. A bit shifted by one position corrupts nearly every code, so a sweep of all codes at the fastest clock exposes it within the first few frames. A divider that latches or clamps the period wrongly shows up as a wrong high-phase length on the first sclk pulse, and as cs_n and busy windows that deviate from multiples of H. A guard or busy fault shows up as a missing or extra select edge on the very next request.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_GUARD = 2'd2
  } rd_state_t;
endpackage

// File: rtl/sar_rd_divider.sv
module sar_rd_divider #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 20,
  parameter int MAX_HALF = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] half_in,
  output logic             tick
);
  localparam logic [DIV_W-1:0] LO = DIV_W'(MIN_HALF);
  localparam logic [DIV_W-1:0] HI = DIV_W'(MAX_HALF);

  logic [DIV_W-1:0] half_q, half_d, cnt_q, cnt_d;

  assign tick = run && (cnt_q == half_q - 1'b1);

  always_comb begin
    half_d = half_q;
    if (load) begin
      if (half_in < LO)      half_d = LO;
      else if (half_in > HI) half_d = HI;
      else                   half_d = half_in;
    end
    if (load || !run) cnt_d = '0;
    else if (tick)    cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= LO;
      cnt_q  <= '0;
    end else begin
      half_q <= half_d;
      cnt_q  <= cnt_d;
    end
  end

  // R3
  half_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half_q));
endmodule

// File: rtl/sar_rd_sequencer.sv
module sar_rd_sequencer
  import sar_rd_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic cs_n,
  output logic sclk,
  output logic busy,
  output logic run,
  output logic load,
  output logic smp_null,
  output logic smp_data,
  output logic smp_last
);
  localparam int LAST_E = 2 * RES_BITS + 5;
  localparam int EW     = $clog2(LAST_E + 1);
  localparam logic [EW-1:0] E_NULL  = EW'(4);
  localparam logic [EW-1:0] E_FIRST = EW'(6);
  localparam logic [EW-1:0] E_LSB   = EW'(2 * RES_BITS + 4);
  localparam logic [EW-1:0] E_END   = EW'(LAST_E);

  rd_state_t   st_q, st_d;
  logic [EW-1:0] e_q, e_d;
  logic        sclk_q, sclk_d, cs_q, cs_d;
  logic        rise;

  assign load = (st_q == ST_IDLE) && start;
  assign run  = (st_q != ST_IDLE);
  assign busy = run;
  assign cs_n = cs_q;
  assign sclk = sclk_q;
  assign rise = (st_q == ST_RUN) && tick && !sclk_q;
  assign smp_null = rise && (e_q == E_NULL);
  assign smp_data = rise && (e_q >= E_FIRST) && (e_q <= E_LSB);
  assign smp_last = rise && (e_q == E_LSB);

  always_comb begin
    st_d   = st_q;
    e_d    = e_q;
    sclk_d = sclk_q;
    cs_d   = cs_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_RUN;
        cs_d   = 1'b0;
        e_d    = '0;
        sclk_d = 1'b0;
      end
      ST_RUN: if (tick) begin
        sclk_d = ~sclk_q;
        e_d    = e_q + 1'b1;
        if (e_q == E_END) begin
          st_d   = ST_GUARD;
          cs_d   = 1'b1;
          sclk_d = 1'b0;
          e_d    = '0;
        end
      end
      ST_GUARD: if (tick) begin
        e_d = e_q + 1'b1;
        if (e_q == EW'(1)) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      e_q    <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      e_q    <= e_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
    end
  end
endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture #(
  parameter int RES_BITS = 12,
  parameter int WORD_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              smp_null,
  input  logic              smp_data,
  input  logic              smp_last,
  output logic [WORD_W-1:0] word,
  output logic              word_vld,
  output logic              frame_err
);
  localparam int PAD = WORD_W - RES_BITS;

  logic [RES_BITS-1:0] sh_q, sh_d, res_q, res_d;
  logic                nul_q, nul_d, vld_q, vld_d;

  always_comb begin
    sh_d  = sh_q;
    res_d = res_q;
    nul_d = nul_q;
    vld_d = 1'b0;
    if (smp_null) nul_d = sdi;
    if (smp_data) sh_d = {sh_q[RES_BITS-2:0], sdi};
    if (smp_last) begin
      res_d = {sh_q[RES_BITS-2:0], sdi};
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      res_q <= '0;
      nul_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      res_q <= res_d;
      nul_q <= nul_d;
      vld_q <= vld_d;
    end
  end

  generate
    if (PAD > 0) begin : g_pad
      assign word = {res_q, {PAD{1'b0}}};
    end else begin : g_full
      assign word = res_q;
    end
  endgenerate

  assign word_vld  = vld_q;
  assign frame_err = vld_q & nul_q;

  // R6
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
endmodule

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl #(
  parameter int RES_BITS = 12,
  parameter int WORD_W   = 12,
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 20,
  parameter int MAX_HALF = 200
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  half_period,
  output logic              cs_n,
  output logic              sclk,
  input  logic              sdi,
  output logic              busy,
  output logic [WORD_W-1:0] word,
  output logic              word_vld,
  output logic              frame_err
);
  logic rs0_q, rs1_q, rst_n;
  logic tick, run, load, smp_null, smp_data, smp_last;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_n = rs1_q;

  sar_rd_divider #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load),
    .half_in(half_period), .tick(tick));

  sar_rd_sequencer #(.RES_BITS(RES_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .run(run), .load(load),
    .smp_null(smp_null), .smp_data(smp_data), .smp_last(smp_last));

  sar_rd_capture #(.RES_BITS(RES_BITS), .WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .sdi(sdi),
    .smp_null(smp_null), .smp_data(smp_data), .smp_last(smp_last),
    .word(word), .word_vld(word_vld), .frame_err(frame_err));

  // R4
  cs_edge_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != $past(cs_n)) |-> !sclk);
  // R2
  select_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  // R6
  vld_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> !cs_n);
  // R1
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && cs_n));
  // R7
  err_only_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> word_vld);
endmodule

// File: tb/sim_sar_rd_ctrl.sv
module sim_sar_rd_ctrl;
  localparam int N = 10, WW = 12, DW = 6, LO = 2, HI = 40;

  logic clk = 1'b0, arst_n = 1'b0, start = 1'b0, sdi = 1'b1;
  logic [DW-1:0] half_period = '0;
  logic cs_n, sclk, busy, word_vld, frame_err;
  logic [WW-1:0] word;

  always #10 clk = ~clk;

  sar_rd_ctrl #(.RES_BITS(N), .WORD_W(WW), .DIV_W(DW), .MIN_HALF(LO), .MAX_HALF(HI)) u0 (
    .clk(clk), .arst_n(arst_n), .start(start), .half_period(half_period),
    .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .busy(busy), .word(word),
    .word_vld(word_vld), .frame_err(frame_err));

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model: changes data on falling sclk
  logic [N-1:0] dev_word = '0;
  logic         dev_null = 1'b0;
  int           falls = 0;
  always @(negedge cs_n) falls = 0;
  always @(posedge cs_n) sdi = 1'b1;
  always @(negedge sclk) if (!cs_n) begin
    falls++;
    if (falls == 2)                      sdi = dev_null;
    else if (falls >= 3 && falls <= N+2) sdi = dev_word[N-1-(falls-3)];
    else                                 sdi = 1'b0;
  end

  // port monitor
  int rises, hi_cnt, hi_min, hi_max, cs_low, busy_len, cs_falls, vld_cnt, bad_sclk_cs;
  int got_word, got_err, err_no_vld;
  logic p_sclk = 1'b0, p_cs = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (!cs_n) cs_low++;
    if (busy)  busy_len++;
    if (p_cs && !cs_n) cs_falls++;
    if ((p_cs != cs_n) && sclk) bad_sclk_cs++;
    if (!p_sclk && sclk) begin
      if (!cs_n) rises++;
      hi_cnt = 0;
    end
    if (sclk) hi_cnt++;
    if (p_sclk && !sclk) begin
      if (hi_cnt < hi_min) hi_min = hi_cnt;
      if (hi_cnt > hi_max) hi_max = hi_cnt;
    end
    if (word_vld) begin
      vld_cnt++;
      got_word = int'(word);
      got_err  = int'(frame_err);
      if (cs_n) bad_sclk_cs++;
    end else if (frame_err) err_no_vld++;
    p_sclk = sclk;
    p_cs   = cs_n;
  end

  function automatic int clampv(input int v);
    return (v < LO) ? LO : (v > HI) ? HI : v;
  endfunction

  task automatic frame(input int hp, input int code, input bit nv,
                       input bit poke, input bit full);
    int h;
    h = clampv(hp);
    dev_word = N'(code);
    dev_null = nv;
    half_period = DW'(hp);
    rises = 0; hi_min = 1000000; hi_max = 0; cs_low = 0; busy_len = 0;
    cs_falls = 0; vld_cnt = 0; bad_sclk_cs = 0; got_word = -1; got_err = -1; err_no_vld = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!cs_n && busy, "R2 select low after start", int'(cs_n), 0);
    if (poke) begin
      repeat (7) @(negedge clk);
      half_period = DW'(clampv(hp) == HI ? LO : HI);
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (3 * h) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(got_word == (code << (WW - N)), "R5 R6 word", got_word, code << (WW - N));
    chk(got_err == int'(nv), "R7 null error flag", got_err, int'(nv));
    chk(vld_cnt == 1 && err_no_vld == 0, "R6 R7 strobe count", vld_cnt, 1);
    if (full) begin
      chk(rises == N + 3, "R4 rising edges", rises, N + 3);
      chk(cs_low == (2*N+6)*h, "R4 select low time", cs_low, (2*N+6)*h);
      chk(hi_min == h && hi_max == h, "R3 high phase", hi_max, h);
      chk(busy_len == (2*N+8)*h, "R2 busy length", busy_len, (2*N+8)*h);
      chk(busy_len - cs_low == 2*h, "R8 guard length", busy_len - cs_low, 2*h);
      chk(bad_sclk_cs == 0, "R4 R6 sclk low at select edges", bad_sclk_cs, 0);
      chk(cs_falls == 1, "R9 single select fall", cs_falls, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !word_vld, "R1 during reset", int'(cs_n), 1);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 && word_vld === 1'b0,
        "R1 after reset", int'(busy), 0);
    // R3 R4 R8: divider sweep with clamping at both ends
    for (int hp = 0; hp < 46; hp++) frame(hp, (hp * 37 + 5) % (1 << N), 1'b0, 1'b0, 1'b1);
    // R9 and R3 latching: requests and period changes during a frame
    frame(3, 10'h2a5, 1'b0, 1'b1, 1'b1);
    frame(HI, 10'h15a, 1'b0, 1'b1, 1'b1);
    // R7: null bit read high
    frame(2, 10'h3ff, 1'b1, 1'b0, 1'b1);
    frame(5, 10'h000, 1'b1, 1'b0, 1'b1);
    // R5 R6: every code at the fastest clock
    for (int c = 0; c < (1 << N); c++) frame(0, c, 1'b0, 1'b0, (c % 64) == 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule